// File: doc/BRIEF.md
# Debug Instruction Injector for a DMA Channel Array

This block lets software start or abort a DMA channel without any program already running on the controller. Software loads an instruction into two injection registers. The first holds an opcode byte and a channel selector. The second holds a 32-bit operand. Software then writes zero to a command register. The block decodes the loaded instruction and acts on it.

A start instruction hands its operand, the program start address, to the selected channel together with a one-cycle start strobe. An abort instruction sends a one-cycle abort strobe to the selected channel.

A busy bit, readable in a status register, blocks a second command until the first has finished. A malformed instruction produces a fault code instead of a strobe. An instruction that cannot be carried out also produces a fault code.

Top module: `dbg_inject`

## Requirements
- R1: After reset, busy is 0, every start and abort strobe is 0, the fault code is 0 and the start address output is 0.
- R2: Register reads take one cycle: the read data is valid one cycle after the address is presented. The address map is: offset 0xD00 gives the busy flag in bit 0; 0xD08 returns the first instruction word; 0xD0C returns the operand word.
- R3: A write of value zero to offset 0xD04 while busy is 0 accepts the command, and busy reads 1 after that edge. A write of any non-zero value to 0xD04 is ignored and leaves busy at 0.
- R4: Opcode byte 0xA0 in bits [23:16] of the first word is a start. Bits [10:8] hold the channel index plus one. A start to a stopped channel raises that channel's start strobe for exactly one cycle, on the second edge after acceptance. The start address output then equals the operand word.
- R5: Opcode byte 0x01 is an abort. It raises the selected channel's abort strobe with the same timing as a start, whether or not the channel is stopped.
- R6: Busy stays high for exactly two cycles. It falls on the edge that ends the strobe, so the bit is clear one cycle after the strobe was issued.
- R7: A start aimed at a channel that is not stopped issues no strobe. It sets fault code bit 4, and the start address output keeps its old value.
- R8: A channel selector of 0, or one above the channel count, issues no strobe and sets fault code bit 1.
- R9: Any opcode byte other than 0xA0 or 0x01 issues no strobe and sets fault code bit 0. This fault takes priority over a bad selector.
- R10: A command write that arrives while busy is 1 is ignored. It causes no strobe, no fault change and no extra busy cycle.
- R11: The fault code is set on the same edge where a strobe would have appeared. It holds until the next accepted command, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 12 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte offset |
| rd_data | output | 32 | Registered read data |
| chan_stopped | input | NCH | Per-channel stopped indication |
| busy | output | 1 | Command in progress |
| start_stb | output | NCH | One-cycle start strobe per channel |
| abort_stb | output | NCH | One-cycle abort strobe per channel |
| start_pc | output | 32 | Program start address for the started channel |
| fault_code | output | 32 | Fault type bits of the last command |

## Verification
Every cycle, the assertions check the following:
- at most one strobe is high, and only while busy;
- busy falls right after a strobe;
- a start strobe only reaches a channel that was stopped;
- a strobe never coexists with a fault code.

The exact cycle of each strobe, the operand passed through, the fault priority, and the discarding of non-zero and mid-command writes can only be shown by the bench's command sequences. Those sequences compare the outputs against a model of the decode rules.

// File: rtl/dbg_inject_pkg.sv
package dbg_inject_pkg;
  localparam logic [11:0] OFS_STATUS = 12'hD00;
  localparam logic [11:0] OFS_CMD    = 12'hD04;
  localparam logic [11:0] OFS_WORD0  = 12'hD08;
  localparam logic [11:0] OFS_WORD1  = 12'hD0C;
  localparam logic [7:0]  OPC_START  = 8'hA0;
  localparam logic [7:0]  OPC_ABORT  = 8'h01;
  localparam int FLT_UNDEF   = 0;
  localparam int FLT_OPERAND = 1;
  localparam int FLT_START   = 4;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DONE} seq_state_t;
endpackage

// File: rtl/dbg_inject_regs.sv
module dbg_inject_regs
  import dbg_inject_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic          busy,
  output logic [DW-1:0] word0,
  output logic [DW-1:0] word1,
  output logic [DW-1:0] rd_data,
  output logic          cmd_fire
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word0 <= '0;
      word1 <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(OFS_WORD0)) word0 <= wr_data;
      if (wr_addr == AW'(OFS_WORD1)) word1 <= wr_data;
    end
  end

  assign cmd_fire = wr_en && (wr_addr == AW'(OFS_CMD)) && (wr_data == '0) && !busy;

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        AW'(OFS_STATUS): rd_data <= DW'(busy);
        AW'(OFS_WORD0):  rd_data <= word0;
        AW'(OFS_WORD1):  rd_data <= word1;
        default:         rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dbg_inject_decode.sv
module dbg_inject_decode
  import dbg_inject_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CSW = 3,
  parameter int CIW = 2
) (
  input  logic [7:0]     opcode,
  input  logic [CSW-1:0] chsel,
  output logic           is_start,
  output logic           is_abort,
  output logic           undef,
  output logic           bad_chan,
  output logic [CIW-1:0] chan_idx
);
  logic [CSW-1:0] sel_m1;
  always_comb begin
    is_start = (opcode == OPC_START);
    is_abort = (opcode == OPC_ABORT);
    undef    = !(is_start || is_abort);
    bad_chan = (chsel == '0) || (int'(chsel) > NCH);
    sel_m1   = chsel - CSW'(1);
    chan_idx = sel_m1[CIW-1:0];
  end
endmodule

// File: rtl/dbg_inject.sv
module dbg_inject
  import dbg_inject_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic [NCH-1:0] chan_stopped,
  output logic           busy,
  output logic [NCH-1:0] start_stb,
  output logic [NCH-1:0] abort_stb,
  output logic [31:0]    start_pc,
  output logic [31:0]    fault_code
);
  localparam int CSW = $clog2(NCH + 1) < 1 ? 1 : $clog2(NCH + 1);
  localparam int CIW = NCH > 1 ? $clog2(NCH) : 1;

  logic [DW-1:0] word0, word1;
  logic          cmd_fire;
  logic          d_start, d_abort, d_undef, d_bad;
  logic [CIW-1:0] d_idx;

  dbg_inject_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .busy(busy), .word0(word0), .word1(word1),
    .rd_data(rd_data), .cmd_fire(cmd_fire)
  );

  dbg_inject_decode #(.NCH(NCH), .CSW(CSW), .CIW(CIW)) u_dec (
    .opcode(word0[23:16]), .chsel(word0[8 +: CSW]),
    .is_start(d_start), .is_abort(d_abort), .undef(d_undef),
    .bad_chan(d_bad), .chan_idx(d_idx)
  );

  seq_state_t     state;
  logic           l_start, l_undef, l_bad;
  logic [CIW-1:0] l_idx;
  logic [31:0]    l_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      busy       <= 1'b0;
      start_stb  <= '0;
      abort_stb  <= '0;
      start_pc   <= '0;
      fault_code <= '0;
      l_start    <= 1'b0;
      l_undef    <= 1'b0;
      l_bad      <= 1'b0;
      l_idx      <= '0;
      l_pc       <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_fire) begin
          state      <= ST_ISSUE;
          busy       <= 1'b1;
          fault_code <= '0;
          l_start    <= d_start;
          l_undef    <= d_undef;
          l_bad      <= d_bad;
          l_idx      <= d_idx;
          l_pc       <= 32'(word1);
        end
        ST_ISSUE: begin
          state <= ST_DONE;
          if (l_undef)                         fault_code[FLT_UNDEF]   <= 1'b1;
          else if (l_bad)                      fault_code[FLT_OPERAND] <= 1'b1;
          else if (l_start && !chan_stopped[l_idx]) fault_code[FLT_START] <= 1'b1;
          else if (l_start) begin
            start_stb[l_idx] <= 1'b1;
            start_pc         <= l_pc;
          end else begin
            abort_stb[l_idx] <= 1'b1;
          end
        end
        default: begin
          state     <= ST_IDLE;
          busy      <= 1'b0;
          start_stb <= '0;
          abort_stb <= '0;
        end
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_stb, abort_stb})); // R4
  AST_STROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (|{start_stb, abort_stb}) |-> busy); // R6
  AST_BUSY_FALLS_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    (|{start_stb, abort_stb}) |=> !busy); // R6
  AST_NO_STROBE_WITH_FAULT: assert property (@(posedge clk) disable iff (rst)
    (|{start_stb, abort_stb}) |-> (fault_code == '0)); // R7
  AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy); // R6

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_START_ONLY_STOPPED: assert property (@(posedge clk) disable iff (rst)
      start_stb[g] |-> $past(chan_stopped[g])); // R7
  end
endmodule

// File: tb/dbg_inject_test.sv
module dbg_inject_test;
  localparam int NCH = 4;
  logic clk = 0, rst = 1;
  logic wr_en = 0;
  logic [11:0] wr_addr = 0, rd_addr = 12'hD00;
  logic [31:0] wr_data = 0, rd_data, start_pc, fault_code;
  logic [NCH-1:0] chan_stopped = '1, start_stb, abort_stb;
  logic busy;
  int n_run = 0, n_fail = 0;
  logic [31:0] exp_pc = 0;

  always #2.5 clk = ~clk;

  dbg_inject #(.NCH(NCH)) uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_fault(logic [7:0] op, int fld, logic [NCH-1:0] stp);
    if (op != 8'hA0 && op != 8'h01) return 32'h1;
    if (fld == 0 || fld > NCH) return 32'h2;
    if (op == 8'hA0 && !stp[fld-1]) return 32'h10;
    return 32'h0;
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  // Runs one command; when poke is set, a second command write lands while busy.
  task automatic run_cmd(logic [7:0] op, int fld, logic [31:0] opnd,
                         logic [NCH-1:0] stp, bit poke);
    logic [31:0] ef;
    logic [NCH-1:0] es, ea;
    wr(12'hD08, {8'h0, op, 5'h0, 3'(fld), 8'h0});
    wr(12'hD0C, opnd);
    chan_stopped = stp;
    ef = model_fault(op, fld, stp);
    es = '0; ea = '0;
    if (ef == 0) begin
      if (op == 8'hA0) begin es[fld-1] = 1; exp_pc = opnd; end
      else ea[fld-1] = 1;
    end
    @(negedge clk);
    wr_en = 1; wr_addr = 12'hD04; wr_data = 0;
    @(negedge clk);
    wr_en = poke; // second write at edge E2 while busy (R10)
    chk("R3 busy after accept", 32'(busy), 1);
    chk("R11 fault cleared on accept", fault_code, 0);
    @(negedge clk);
    wr_en = 0;
    chk("R6 busy during issue", 32'(busy), 1);
    chk("R4 R5 start strobe", 32'(start_stb), 32'(es));
    chk("R5 abort strobe", 32'(abort_stb), 32'(ea));
    chk("R7 R8 R9 fault code", fault_code, ef);
    chk("R4 R7 start address", start_pc, exp_pc);
    @(negedge clk);
    chk("R6 busy cleared", 32'(busy), 0);
    chk("R10 strobes quiet after", 32'({start_stb, abort_stb}), 0);
    chk("R11 fault held", fault_code, ef);
    if (poke) begin
      @(negedge clk);
      chk("R10 no extra busy", 32'(busy), 0);
    end
  endtask

  initial begin
    #200000;
    n_fail++; n_run++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 busy reset", 32'(busy), 0);
    chk("R1 strobes reset", 32'({start_stb, abort_stb}), 0);
    chk("R1 fault reset", fault_code, 0);
    chk("R1 pc reset", start_pc, 0);
    // R2 readback
    wr(12'hD08, 32'h00A0_0300);
    wr(12'hD0C, 32'hCAFE_0010);
    @(negedge clk); rd_addr = 12'hD08;
    @(negedge clk); chk("R2 read word0", rd_data, 32'h00A0_0300);
    rd_addr = 12'hD0C;
    @(negedge clk); chk("R2 read word1", rd_data, 32'hCAFE_0010);
    rd_addr = 12'hD00;
    @(negedge clk); chk("R2 read status idle", rd_data, 0);
    // R3 non-zero command ignored
    wr(12'hD04, 32'h1);
    chk("R3 nonzero ignored", 32'(busy), 0);
    @(negedge clk); chk("R3 no strobe", 32'({start_stb, abort_stb}), 0);
    // R2 status busy readback
    @(negedge clk); wr_en = 1; wr_addr = 12'hD04; wr_data = 0;
    @(negedge clk); wr_en = 0;
    @(negedge clk); chk("R2 read status busy", rd_data, 1);
    @(negedge clk);
    // directed corners
    run_cmd(8'hA0, 1, 32'h1000_0000, 4'hF, 0);   // R4 start
    run_cmd(8'hA0, NCH, 32'h2000_0040, 4'hF, 0); // R4 last channel
    run_cmd(8'h01, 2, 32'h0, 4'h0, 0);           // R5 abort running
    run_cmd(8'hA0, 3, 32'h3333_3333, 4'hB, 0);   // R7 not stopped
    run_cmd(8'hA0, 0, 32'h4, 4'hF, 0);           // R8 selector zero
    run_cmd(8'h01, NCH + 1, 32'h4, 4'hF, 0);     // R8 selector high
    run_cmd(8'h55, 0, 32'h4, 4'hF, 0);           // R9 priority over R8
    run_cmd(8'hA0, 2, 32'h5000_0000, 4'hF, 1);   // R10 write while busy
    for (int i = 0; i < 60; i++) begin
      logic [7:0] op;
      int sel = $urandom_range(0, 3);
      op = (sel < 2) ? 8'hA0 : (sel == 2) ? 8'h01 : 8'($urandom);
      run_cmd(op, $urandom_range(0, 7), $urandom, NCH'($urandom), bit'($urandom_range(0, 1)));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule